// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the entry part of exception processing for a small 32-bit core. A request gives a vector number, a flag that marks it as an interrupt, and that interrupt's level. With the request come the address of the current instruction, the address of the following instruction, the status word and the stack pointer. The block checks the vector and changes any unassigned vector into a format error (vector 14). It saves either the current-instruction address or the following-instruction address, depending on the vector's class. It writes a two-word frame through a word-wide write port that has a ready handshake. Its outputs are the new stack pointer and the new status word. It then gives a one-cycle completion strobe that carries the address of the vector table entry.

When that strobe has been given, the block sets an interrupt-hold flag. The flag stays set until the core reports that an instruction has retired. So the first handler instruction always runs with interrupts held off. While the flag is set, the block also refuses interrupt requests. Fault and trap requests are still accepted.

Top module: `exc_entry_seq`

## Requirements
- R1: On the completion strobe, `vec_addr` equals VEC_BASE (default 0) plus four times the vector that was dispatched. For example, vector 2 gives 0x008 and vector 255 after conversion gives 0x038.
- R2: Vectors 2, 3, 4, 8, 10, 11, 14 and 61 save `pc_cur` as the frame address word.
- R3: Vectors 9, 12, 24, 32 to 47 and 64 to 102 save `pc_next` as the frame address word.
- R4: Every other vector number (0 to 255) is dispatched as vector 14. It saves `pc_cur`, and both the frame and `vec_addr` use 14.
- R5: The first write goes to `sp_in - 4` with the saved address. The second write goes to `sp_in - 8` with the word {format code in bits 31:28, zeros, vector in bits 25:18, zeros in bits 17:16, `sr_in` in bits 15:0}. FMT_CODE defaults to 4.
- R6: While a write waits for `mem_ready`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged. A write completes on a clock edge where both `mem_we` and `mem_ready` are high.
- R7: `done` is high for exactly one cycle. That cycle follows the edge on which the second write completed. In that cycle `sp_out` equals `sp_in - 8`.
- R8: For an interrupt request with `mask_force` low, `sr_out` equals `sr_in` with bits 10:8 replaced by `irq_level`.
- R9: For an interrupt request with `mask_force` high, `sr_out` equals `sr_in` with bits 10:8 set to 7.
- R10: For a request that is not an interrupt, `sr_out` equals `sr_in`.
- R11: `irq_hold` goes high in the cycle after `done`. It goes low in the cycle after an `insn_retired` seen while no `done` is present. It is low after reset.
- R12: While `irq_hold` is high, a request with `req_irq` high is ignored and `busy` stays low. A request with `req_irq` low is accepted.
- R13: A request is accepted only when `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while busy have no effect on the frame being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_vec | input | 8 | Requested vector number |
| req_irq | input | 1 | Request is an interrupt |
| irq_level | input | 3 | Level of the interrupt being taken |
| mask_force | input | 1 | Force the mask to 7 on interrupt entry |
| pc_cur | input | 32 | Address of the instruction that raised the exception |
| pc_next | input | 32 | Address of the following instruction |
| sr_in | input | 16 | Status word at entry |
| sp_in | input | 32 | Stack pointer at entry |
| insn_retired | input | 1 | An instruction has retired |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry complete strobe |
| vec_addr | output | 32 | Vector table entry address |
| sr_out | output | 16 | Updated status word |
| sp_out | output | 32 | Updated stack pointer |
| irq_hold | output | 1 | Interrupt sampling held off |

## Verification
The bench sends every vector number from 0 to 255. A block that classified a vector wrongly would stack the wrong address, and one that let a reserved number through would point into an unused table slot. Interrupt entries are run with the mask force bit both low and high, to catch a mask taken from the wrong source. Random stalls on `mem_ready` check for a write that moves or drops its data while it is still pending. Interrupt requests are also sent while the hold flag is set, or during a sequence in progress. A design that sampled them would start a frame or corrupt the frame being written.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SR_W   = 16;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned LVL_W  = 3;

  typedef enum logic [1:0] {VK_FAULT, VK_NEXT, VK_RESV} vec_kind_e;

  function automatic vec_kind_e vec_kind(input logic [VEC_W-1:0] v);
    if (v inside {8'd2, 8'd3, 8'd4, 8'd8, 8'd10, 8'd11, 8'd14, 8'd61})
      return VK_FAULT;
    if (v inside {8'd9, 8'd12, 8'd24, [8'd32:8'd47], [8'd64:8'd102]})
      return VK_NEXT;
    return VK_RESV;
  endfunction

  function automatic logic [WORD_W-1:0] table_offset(input logic [VEC_W-1:0] v);
    return {{(WORD_W-VEC_W-2){1'b0}}, v, 2'b00};
  endfunction

  function automatic logic [SR_W-1:0] fmt_vec_word(input logic [3:0] fmt,
                                                   input logic [VEC_W-1:0] v);
    return {fmt, 2'b00, v, 2'b00};
  endfunction

  function automatic logic [SR_W-1:0] put_mask(input logic [SR_W-1:0] sr,
                                               input logic [LVL_W-1:0] lvl);
    return {sr[15:11], lvl, sr[7:0]};
  endfunction
endpackage

// File: rtl/exc_vec_classify.sv
module exc_vec_classify
  import exc_pkg::*;
#(
  parameter logic [VEC_W-1:0] FMT_ERR_VEC = 8'd14
) (
  input  logic [VEC_W-1:0]  vec,
  input  logic              is_irq,
  input  logic [LVL_W-1:0]  level,
  input  logic              force7,
  input  logic [WORD_W-1:0] pc_fault,
  input  logic [WORD_W-1:0] pc_follow,
  input  logic [SR_W-1:0]   sr,
  output logic [VEC_W-1:0]  eff_vec,
  output logic [WORD_W-1:0] saved_pc,
  output logic [SR_W-1:0]   sr_new
);
  vec_kind_e kind_raw;
  logic      rsv_hit;

  always_comb begin
    kind_raw = vec_kind(vec);
    rsv_hit  = (kind_raw == VK_RESV);
    eff_vec  = rsv_hit ? FMT_ERR_VEC : vec;
    saved_pc = (kind_raw == VK_NEXT) ? pc_follow : pc_fault;
    if (is_irq) sr_new = put_mask(sr, force7 ? 3'd7 : level);
    else        sr_new = sr;
  end

  always_comb begin
    p_eff_assigned_r4: assert (vec_kind(eff_vec) != VK_RESV || $isunknown(vec));
  end
endmodule

// File: rtl/exc_frame_writer.sv
module exc_frame_writer
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] frame_sp,
  input  logic [WORD_W-1:0] pc_word,
  input  logic [WORD_W-1:0] hdr_word,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {W_IDLE, W_PC, W_HDR, W_FIN} wstate_e;
  wstate_e st;
  logic [WORD_W-1:0] sp_q, pc_q, hdr_q;
  logic write_fire;

  assign write_fire = mem_we && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= W_IDLE;
      sp_q  <= '0;
      pc_q  <= '0;
      hdr_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          st    <= W_PC;
          sp_q  <= frame_sp;
          pc_q  <= pc_word;
          hdr_q <= hdr_word;
        end
        W_PC:   if (mem_ready) st <= W_HDR;
        W_HDR:  if (mem_ready) st <= W_FIN;
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = (st == W_PC) || (st == W_HDR);
    mem_addr  = '0;
    mem_wdata = '0;
    if (st == W_PC) begin
      mem_addr  = sp_q + WORD_W'(4);
      mem_wdata = pc_q;
    end else if (st == W_HDR) begin
      mem_addr  = sp_q;
      mem_wdata = hdr_q;
    end
    busy = (st != W_IDLE);
    done = (st == W_FIN);
  end

  p_write_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(write_fire));
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic entry_done,
  input  logic retired,
  output logic hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold <= 1'b0;
    else if (entry_done) hold <= 1'b1;
    else if (retired)    hold <= 1'b0;
  end

  p_hold_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> hold);
  p_hold_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && retired && !entry_done) |=> !hold);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE    = 32'h0000_0000,
  parameter logic [3:0]        FMT_CODE    = 4'h4,
  parameter logic [VEC_W-1:0]  FMT_ERR_VEC = 8'd14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic              req_irq,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              mask_force,
  input  logic [WORD_W-1:0] pc_cur,
  input  logic [WORD_W-1:0] pc_next,
  input  logic [SR_W-1:0]   sr_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic              insn_retired,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] vec_addr,
  output logic [SR_W-1:0]   sr_out,
  output logic [WORD_W-1:0] sp_out,
  output logic              irq_hold
);
  localparam int unsigned FRAME_BYTES = 2 * (WORD_W / 8);

  logic [VEC_W-1:0]  eff_vec;
  logic [WORD_W-1:0] saved_pc;
  logic [SR_W-1:0]   sr_new;
  logic [WORD_W-1:0] new_sp;
  logic [WORD_W-1:0] hdr_word;
  logic              accept;

  exc_vec_classify #(.FMT_ERR_VEC(FMT_ERR_VEC)) i_classify (
    .vec(req_vec), .is_irq(req_irq), .level(irq_level), .force7(mask_force),
    .pc_fault(pc_cur), .pc_follow(pc_next), .sr(sr_in),
    .eff_vec(eff_vec), .saved_pc(saved_pc), .sr_new(sr_new)
  );

  assign new_sp   = sp_in - WORD_W'(FRAME_BYTES);
  assign hdr_word = {fmt_vec_word(FMT_CODE, eff_vec), sr_in};
  assign accept   = req_valid && !busy && !(req_irq && irq_hold);

  exc_frame_writer i_writer (
    .clk(clk), .rst_n(rst_n), .start(accept), .frame_sp(new_sp),
    .pc_word(saved_pc), .hdr_word(hdr_word), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done)
  );

  exc_irq_gate i_gate (
    .clk(clk), .rst_n(rst_n), .entry_done(done), .retired(insn_retired),
    .hold(irq_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_addr <= '0;
      sr_out   <= '0;
      sp_out   <= '0;
    end else if (accept) begin
      vec_addr <= VEC_BASE + table_offset(eff_vec);
      sr_out   <= sr_new;
      sp_out   <= new_sp;
    end
  end

  p_irq_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hold && req_irq && !busy) |=> !busy);
  p_busy_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(sp_out) && $stable(vec_addr)));
  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_irq = 1'b0, mask_force = 1'b0;
  logic insn_retired = 1'b0, mem_ready = 1'b1;
  logic [7:0] req_vec = '0;
  logic [2:0] irq_level = '0;
  logic [31:0] pc_cur = '0, pc_next = '0, sp_in = '0;
  logic [15:0] sr_in = '0;
  logic mem_we, busy, done, irq_hold;
  logic [31:0] mem_addr, mem_wdata, vec_addr, sp_out;
  logic [15:0] sr_out;

  int checks = 0, errors = 0;
  bit stall_mode = 0;
  bit finished = 0;

  // reference model state
  int m_phase = 0;
  bit m_hold = 0;
  logic [31:0] m_sp = 0, m_pc = 0, m_hdr = 0, m_vaddr = 0, m_spout = 0;
  logic [15:0] m_sr = 0;
  bit m_live = 0;

  always #5 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_irq(req_irq), .irq_level(irq_level), .mask_force(mask_force),
    .pc_cur(pc_cur), .pc_next(pc_next), .sr_in(sr_in), .sp_in(sp_in),
    .insn_retired(insn_retired), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .vec_addr(vec_addr), .sr_out(sr_out), .sp_out(sp_out), .irq_hold(irq_hold)
  );

  function automatic int classify(input int v); // 0 fault, 1 next, 2 unassigned
    int f[8] = '{2, 3, 4, 8, 10, 11, 14, 61};
    foreach (f[i]) if (f[i] == v) return 0;
    if (v == 9 || v == 12 || v == 24) return 1;
    if (v >= 32 && v <= 47) return 1;
    if (v >= 64 && v <= 102) return 1;
    return 2;
  endfunction

  // model advances on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_hold = 0; m_spout = 0; m_vaddr = 0; m_sr = 0;
    end else begin
      bit was_done;
      was_done = (m_phase == 3);
      case (m_phase)
        0: if (req_valid && !(req_irq && m_hold)) begin
          int v, c;
          v = req_vec; c = classify(v);
          if (c == 2) begin v = 14; c = 0; end
          m_pc = (c == 1) ? pc_next : pc_cur;
          m_sp = sp_in - 8;
          m_spout = m_sp;
          m_hdr = {4'h4, 2'b00, 8'(v), 2'b00, sr_in};
          m_vaddr = v * 4;
          if (req_irq) m_sr = (sr_in & 16'hF8FF) | (16'(mask_force ? 7 : irq_level) << 8);
          else m_sr = sr_in;
          m_phase = 1;
        end
        1: if (mem_ready) m_phase = 2;
        2: if (mem_ready) m_phase = 3;
        default: m_phase = 0;
      endcase
      if (was_done) m_hold = 1;
      else if (insn_retired) m_hold = 0;
      m_live = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_live && !finished) begin
      chk(busy == (m_phase != 0), "R13 busy", 32'(busy), 32'(m_phase != 0));
      chk(mem_we == (m_phase == 1 || m_phase == 2), "R6 mem_we", 32'(mem_we), 32'(m_phase == 1 || m_phase == 2));
      if (m_phase == 1) begin
        chk(mem_addr == m_sp + 4, "R5 first addr", mem_addr, m_sp + 4);
        chk(mem_wdata == m_pc, "R2 R3 R4 saved address", mem_wdata, m_pc);
      end
      if (m_phase == 2) begin
        chk(mem_addr == m_sp, "R5 second addr", mem_addr, m_sp);
        chk(mem_wdata == m_hdr, "R5 R4 header word", mem_wdata, m_hdr);
      end
      chk(done == (m_phase == 3), "R7 done", 32'(done), 32'(m_phase == 3));
      if (m_phase == 3) begin
        chk(vec_addr == m_vaddr, "R1 R4 vec_addr", vec_addr, m_vaddr);
        chk(sp_out == m_spout, "R7 sp_out", sp_out, m_spout);
        chk(sr_out == m_sr, "R8 R9 R10 sr_out", 32'(sr_out), 32'(m_sr));
      end
      chk(irq_hold == m_hold, "R11 R12 irq_hold", 32'(irq_hold), 32'(m_hold));
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(input int v, input bit irq, input int lvl, input bit frc);
    tick(1);
    req_valid = 1; req_vec = 8'(v); req_irq = irq; irq_level = 3'(lvl);
    mask_force = frc;
    pc_cur = $urandom & 32'hFFFF_FFFE; pc_next = pc_cur + 2 + 2 * ($urandom % 3);
    sr_in = 16'($urandom); sp_in = 32'h0001_0000 + 4 * ($urandom % 256);
    tick(1);
    req_valid = 0; req_vec = 8'($urandom); sr_in = 16'($urandom); sp_in = $urandom;
    tick(1);
    while (busy) tick(1);
  endtask

  task automatic retire;
    insn_retired = 1; tick(1); insn_retired = 0;
  endtask

  initial begin
    fork
      forever begin
        @(posedge clk); #2;
        mem_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
      end
    join_none
    #1;
    chk(busy == 0 && mem_we == 0 && done == 0 && irq_hold == 0, "R11 R13 reset state",
        {mem_we, busy, done, irq_hold}, 0);
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 R2 R3 R4 R10: every vector as a non-interrupt request
    for (int v = 0; v < 256; v++) begin
      send(v, 0, 0, 0);
      tick(1);
      retire();
    end
    // R8 R9: interrupt entries with and without forced mask
    for (int k = 0; k < 16; k++) begin
      send(64 + k, 1, k % 8, k[0]);
      tick(1);
      retire();
    end
    // R12: interrupt while hold set is ignored; fault still taken
    send(70, 1, 3, 0);
    send(71, 1, 5, 0);
    tick(3);
    send(4, 0, 0, 0);
    tick(2);
    retire();
    send(72, 1, 2, 1);
    retire();
    // R13: extra request while busy, R6: random stalls
    stall_mode = 1;
    for (int k = 0; k < 40; k++) begin
      tick(1);
      req_valid = 1; req_vec = 8'(k * 7); req_irq = 0;
      sr_in = 16'($urandom); sp_in = 32'h2000 + 8 * k; pc_cur = $urandom; pc_next = $urandom;
      tick(2);
      req_valid = 1; req_vec = 8'd33; sp_in = 32'hDEAD_0000;
      tick(1);
      req_valid = 0;
      while (busy) tick(1);
      if (k % 3 == 0) retire();
    end
    stall_mode = 0;
    tick(4);
    // R11: retire coinciding with done leaves hold set
    tick(1);
    req_valid = 1; req_vec = 8'd9; req_irq = 0; tick(1); req_valid = 0;
    while (!done) tick(1);
    insn_retired = 1; tick(1); insn_retired = 0;
    tick(3);
    retire();
    tick(3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule